// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a serial bit stream, one bit per clock, and raises two separate flags. `tri_hit` marks the cycle in which the three most recent bits, oldest first, are 1 then 0 then 1. `pair_hit` marks the cycle in which the two most recent bits are both 1. One small state register serves both patterns. The flags are Mealy outputs. Each is decoded from the present state and the bit now on `x_in`, so it rises in the same cycle as the final bit of its pattern. It drops again on the next bit unless that bit completes another pattern.

Matches may overlap. The closing 1 of either pattern also counts as the opening 1 of the next pattern. After a match the machine carries on detecting and is never forced back to a blank history.

The reset input is asynchronous and active-low. Asserting it clears the machine at once. Its release passes through a short synchroniser inside the block, so the state starts moving a fixed number of clock edges after `rst_n` rises.

Top module: `dual_pattern_detector`

## Requirements
- R1: While `rst_n` is low, and for the synchroniser delay after it rises, both flags read 0 and the bit history counts as all zeros, whatever `x_in` carries.
- R2: `tri_hit` is 1 exactly when `x_in` is 1, the previously accepted bit was 0 and the bit accepted before that was 1.
- R3: `pair_hit` is 1 exactly when `x_in` is 1 and the previously accepted bit was 1.
- R4: Both flags are combinational in `x_in`. When `x_in` changes within a cycle, the flags follow it before the next clock edge.
- R5: Matches overlap. On the input 1,0,1,0,1, `tri_hit` is set on bits 3 and 5. On 1,0,1,1, `tri_hit` is set on bit 3 and `pair_hit` on bit 4. On 1,1,1, `pair_hit` is set on bits 2 and 3.
- R6: `tri_hit` and `pair_hit` are never 1 in the same cycle.
- R7: Two 0 bits in a row clear the history. After 1,0,0 the input 1 sets neither flag.
- R8: Driving `rst_n` low clears both flags without waiting for a clock edge, even while a flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit is accepted per edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| x_in | input | 1 | Serial data bit |
| tri_hit | output | 1 | Mealy flag for the pattern 1,0,1 |
| pair_hit | output | 1 | Mealy flag for the pattern 1,1 |

## Verification
The state register holds only the last one or two bits that matter. A wrong state shows up at the ports on the first later bit of 1. If the machine wrongly believes the last bit was 1, a spurious `pair_hit` appears at once. If it misses a 1 or a 10 suffix, the pair or triple flag is lost on that same bit. A bad state is therefore visible within one 1 bit, or within three bits after two zeros flush the history. The bench runs a behavioural model of the last two accepted bits alongside the design and compares both flags in every cycle. It runs long random streams as well as directed overlap, flush, mid-cycle and asynchronous-reset cases.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE    = 2'd0,  // no useful suffix
    ST_ONE     = 2'd1,  // last accepted bit was 1
    ST_ONEZERO = 2'd2   // last two accepted bits were 1 then 0
  } dpd_state_e;
endpackage

// File: rtl/dpd_rst_sync.sv
module dpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/dpd_next_state.sv
module dpd_next_state
  import dpd_pkg::*;
(
  input  dpd_state_e cur_state,
  input  logic       bit_in,
  output dpd_state_e nxt_state
);
  always_comb begin
    nxt_state = ST_IDLE;
    unique case (cur_state)
      ST_IDLE:    nxt_state = bit_in ? ST_ONE : ST_IDLE;
      ST_ONE:     nxt_state = bit_in ? ST_ONE : ST_ONEZERO;
      ST_ONEZERO: nxt_state = bit_in ? ST_ONE : ST_IDLE;
      default:    nxt_state = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dpd_flag_decode.sv
module dpd_flag_decode
  import dpd_pkg::*;
(
  input  dpd_state_e cur_state,
  input  logic       bit_in,
  output logic       tri_flag,
  output logic       pair_flag
);
  always_comb begin
    tri_flag  = 1'b0;
    pair_flag = 1'b0;
    if (bit_in) begin
      tri_flag  = (cur_state == ST_ONEZERO);
      pair_flag = (cur_state == ST_ONE);
    end
  end
endmodule

// File: rtl/dpd_state_reg.sv
module dpd_state_reg
  import dpd_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       run_en,
  input  dpd_state_e nxt_state,
  output dpd_state_e cur_state
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cur_state <= ST_IDLE;
    else if (run_en) cur_state <= nxt_state;
    else             cur_state <= ST_IDLE;
  end
endmodule

// File: rtl/dual_pattern_detector.sv
module dual_pattern_detector
  import dpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x_in,
  output logic tri_hit,
  output logic pair_hit
);
  logic       core_rst_n;
  dpd_state_e cur_state;
  dpd_state_e nxt_state;

  dpd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  dpd_next_state u_next (
    .cur_state (cur_state),
    .bit_in    (x_in),
    .nxt_state (nxt_state)
  );

  dpd_state_reg u_state (
    .clk       (clk),
    .arst_n    (rst_n),
    .run_en    (core_rst_n),
    .nxt_state (nxt_state),
    .cur_state (cur_state)
  );

  dpd_flag_decode u_flags (
    .cur_state (cur_state),
    .bit_in    (x_in),
    .tri_flag  (tri_hit),
    .pair_flag (pair_hit)
  );
endmodule

// File: rtl/dpd_checker.sv
module dpd_checker
  import dpd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       core_rst_n,
  input logic       x_in,
  input logic       tri_hit,
  input logic       pair_hit,
  input dpd_state_e state
);
  AST_NO_DUAL_HIT: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(tri_hit && pair_hit)); // R6

  AST_PAIR_NEEDS_ONE_NOW: assert property (@(posedge clk) disable iff (!core_rst_n)
    pair_hit |-> x_in); // R3

  AST_PAIR_PREV_ONE: assert property (@(posedge clk) disable iff (!core_rst_n)
    pair_hit |-> $past(x_in)); // R3

  AST_TRI_HISTORY: assert property (@(posedge clk) disable iff (!core_rst_n)
    tri_hit |-> (x_in && !$past(x_in, 1) && $past(x_in, 2))); // R2

  AST_FLUSH_AFTER_ZEROS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!x_in && $past(!x_in) && $past(core_rst_n)) |=> !tri_hit && !pair_hit); // R7

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!core_rst_n)
    state inside {ST_IDLE, ST_ONE, ST_ONEZERO}); // R1

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!tri_hit && !pair_hit); // R8
    end
  end
endmodule

bind dual_pattern_detector dpd_checker u_dpd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .x_in       (x_in),
  .tri_hit    (tri_hit),
  .pair_hit   (pair_hit),
  .state      (cur_state)
);

// File: tb/test_dual_pattern_detector.sv
`timescale 1ns/1ps
module test_dual_pattern_detector;
  logic clk;
  logic rst_n;
  logic x_in;
  logic tri_hit;
  logic pair_hit;

  int checks;
  int failures;
  int h1;  // last accepted bit
  int h2;  // bit accepted before that

  dual_pattern_detector i_dual_pattern_detector (
    .clk      (clk),
    .rst_n    (rst_n),
    .x_in     (x_in),
    .tri_hit  (tri_hit),
    .pair_hit (pair_hit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one bit, compare both flags against the history model, accept it on the edge.
  task automatic drive_bit(input int b, input string req);
    logic et, ep;
    @(negedge clk);
    x_in = b[0];
    #1;
    et = (b == 1) && (h1 == 0) && (h2 == 1);
    ep = (b == 1) && (h1 == 1);
    check(tri_hit, et, et ? req : "R2", "tri_hit");
    check(pair_hit, ep, ep ? req : "R3", "pair_hit");
    check(tri_hit && pair_hit, 1'b0, "R6", "both flags");
    @(posedge clk);
    h2 = h1;
    h1 = b;
  endtask

  task automatic drive_seq(input logic [15:0] bits, input int n, input string req);
    for (int i = n - 1; i >= 0; i--) drive_bit(int'(bits[i]), req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    x_in  = 1'b1;
    #1;
    check(tri_hit, 1'b0, "R1", "tri_hit in reset");
    check(pair_hit, 1'b0, "R1", "pair_hit in reset");
    repeat (3) @(negedge clk);
    check(pair_hit, 1'b0, "R1", "pair_hit in reset, x high");
    rst_n = 1'b1;
    x_in  = 1'b0;
    h1 = 0;
    h2 = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    h1 = 0;
    h2 = 0;
    rst_n = 1'b0;
    x_in = 1'b0;
    do_reset();

    drive_seq(16'b10101, 5, "R5");
    drive_seq(16'b00, 2, "R7");
    drive_seq(16'b1011, 4, "R5");
    drive_seq(16'b00, 2, "R7");
    drive_seq(16'b111, 3, "R5");
    drive_seq(16'b1001, 4, "R7");
    drive_seq(16'b0101, 4, "R2");
    drive_seq(16'b0110, 4, "R3");

    // R4: flags follow x_in within a cycle (state now holds a trailing 1 after "1")
    drive_bit(1, "R3");
    @(negedge clk);
    x_in = 1'b0;
    #1;
    check(pair_hit, 1'b0, "R4", "pair_hit with x low");
    x_in = 1'b1;
    #1;
    check(pair_hit, 1'b1, "R4", "pair_hit after x rises mid-cycle");
    x_in = 1'b0;
    #1;
    check(pair_hit, 1'b0, "R4", "pair_hit after x falls mid-cycle");
    x_in = 1'b1;
    @(posedge clk);
    h2 = h1;
    h1 = 1;

    // R8: asynchronous reset clears a set flag without a clock edge
    @(negedge clk);
    x_in = 1'b1;
    #1;
    check(pair_hit, 1'b1, "R3", "pair_hit before reset");
    rst_n = 1'b0;
    #0.5;
    check(pair_hit, 1'b0, "R8", "pair_hit after async reset");
    check(tri_hit, 1'b0, "R8", "tri_hit after async reset");
    do_reset();

    for (int i = 0; i < 3000; i++) drive_bit(int'($urandom_range(0, 1)), "R5");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule